// File: doc/BRIEF.md
# Counter-Matched Frame Aligner

This block lines up two sample streams that come from separate receivers running on a shared clock. Each stream is a series of frames. A frame is `NCHAN` beats long, and each beat holds one complex 16-bit sample. Beat 0 of every frame is not data: it carries a free-running 32-bit sample number. Its upper half travels in the I lane and its lower half in the Q lane. The remaining beats are the data channels.

The block collects one frame from each side and compares the two sample numbers. While it is aligning, it throws away the whole frame of whichever stream is behind, and repeats this until the numbers agree. From then on it hands out one matched pair of frames per output transfer. It keeps checking every pair. If a pair disagrees, it flags the slip and starts aligning again.

Top module: `sca_stream_aligner`

## Requirements
- R1: While reset is applied and just after it, `o_valid` and `o_err` are 0 and both `a_ready` and `b_ready` are 1.
- R2: The k-th accepted beat of a frame appears in output slot k, at bits `[k*32 +: 32]`. Slot 0 is the sample number, with I (upper half) in bits 31:16 and Q (lower half) in bits 15:0.
- R3: A stream that has delivered a full frame holds its ready low until that frame is forwarded or dropped. A stream never waits on the other stream's frame to finish a frame of its own.
- R4: While aligning, the stream whose sample number is behind has its whole frame discarded. "Behind" means that bit 31 of the 32-bit wrap-around difference (own minus other) is 1. This repeats until the two sample numbers are equal.
- R5: A pair of frames is offered on `o_valid` only when both sample numbers are equal. The pair is consumed on `o_valid && o_ready`, and the first such pair moves the block into the locked state.
- R6: While `o_valid` is high and `o_ready` is low, the offered frames stay unchanged and neither input accepts beats.
- R7: In the locked state, a pair with unequal sample numbers is not forwarded. `o_err` pulses high for exactly one cycle, and the block goes back to aligning and drops frames again.
- R8: The comparison wraps at 2^32. A difference of exactly 2^31 counts stream A as the one behind.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| a_valid | input | 1 | Stream A beat valid |
| a_ready | output | 1 | Stream A can take a beat |
| a_data | input | 32 | Stream A beat, I in 31:16, Q in 15:0 |
| b_valid | input | 1 | Stream B beat valid |
| b_ready | output | 1 | Stream B can take a beat |
| b_data | input | 32 | Stream B beat, I in 31:16, Q in 15:0 |
| o_valid | output | 1 | Matched frame pair available |
| o_ready | input | 1 | Consumer accepts the pair |
| o_a_frame | output | NCHAN*32 | Stream A frame, slot k at [k*32 +: 32] |
| o_b_frame | output | NCHAN*32 | Stream B frame, slot k at [k*32 +: 32] |
| o_err | output | 1 | One-cycle pulse on loss of lock |

## Verification
A wrong choice of which stream lags shows up in a specific way: the side that should advance stops. The other stream sits with its ready held low, and no output appears within a few frame times. A beat index that drifts out of step puts data words into the sample-number slot. Every forwarded pair then fails the slot comparison on the very first output. A state register that fails to leave the locked state, or fails to return to it, shows up as a missing or extra `o_err` pulse. It also shows up as frames that come out without first being dropped, in the cycle right after the mismatched pair is complete.

// File: rtl/sca_pkg.sv
package sca_pkg;
  typedef enum logic {
    ST_ALIGN = 1'b0,
    ST_LOCK  = 1'b1
  } sca_state_e;

  // True when x lags y in wrap-around arithmetic (sign of x - y).
  function automatic logic sca_lags(input logic [31:0] x, input logic [31:0] y);
    logic [31:0] diff;
    diff = x - y;
    return diff[31];
  endfunction
endpackage

// File: rtl/sca_deframer.sv
module sca_deframer #(
  parameter int NCHAN  = 4,
  parameter int BEAT_W = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [BEAT_W-1:0]       in_data,
  input  logic                    take,
  output logic                    full,
  output logic [NCHAN*BEAT_W-1:0] frame
);
  localparam int IDX_W = (NCHAN > 1) ? $clog2(NCHAN) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NCHAN - 1);

  logic [IDX_W-1:0] idx_q, idx_d;
  logic             full_q, full_d;
  logic             accept;

  assign in_ready = !full_q;
  assign accept   = in_valid && !full_q;
  assign full     = full_q;

  always_comb begin
    idx_d  = idx_q;
    full_d = full_q;
    if (accept) begin
      if (idx_q == LAST_IDX) begin
        idx_d  = '0;
        full_d = 1'b1;
      end else begin
        idx_d = idx_q + 1'b1;
      end
    end else if (take) begin
      full_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      full_q <= 1'b0;
    end else begin
      if (accept) idx_q <= idx_d;
      if (accept || take) full_q <= full_d;
    end
  end

  for (genvar k = 0; k < NCHAN; k++) begin : g_slot
    logic [BEAT_W-1:0] slot_q;
    logic              slot_we;
    assign slot_we = accept && (idx_q == IDX_W'(k));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       slot_q <= '0;
      else if (slot_we) slot_q <= in_data;
    end
    assign frame[k*BEAT_W +: BEAT_W] = slot_q;
  end
endmodule

// File: rtl/sca_align_ctrl.sv
module sca_align_ctrl
  import sca_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             full_a,
  input  logic             full_b,
  input  logic [CNT_W-1:0] cnt_a,
  input  logic [CNT_W-1:0] cnt_b,
  input  logic             out_ready,
  output logic             out_valid,
  output logic             take_a,
  output logic             take_b,
  output logic             err
);
  sca_state_e state_q, state_d;
  logic       err_q, slip;
  logic       both, same, a_late;

  assign both   = full_a && full_b;
  assign same   = (cnt_a == cnt_b);
  assign a_late = sca_lags(cnt_a, cnt_b);

  always_comb begin
    state_d   = state_q;
    out_valid = 1'b0;
    take_a    = 1'b0;
    take_b    = 1'b0;
    slip      = 1'b0;
    if (both) begin
      if (same) begin
        out_valid = 1'b1;
        if (out_ready) begin
          take_a  = 1'b1;
          take_b  = 1'b1;
          state_d = ST_LOCK;
        end
      end else if (state_q == ST_LOCK) begin
        slip    = 1'b1;
        state_d = ST_ALIGN;
      end else if (a_late) begin
        take_a = 1'b1;
      end else begin
        take_b = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_ALIGN;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      err_q   <= slip;
    end
  end

  assign err = err_q;
endmodule

// File: rtl/sca_stream_aligner.sv
module sca_stream_aligner #(
  parameter int NCHAN  = 4,
  parameter int HALF_W = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        a_valid,
  output logic                        a_ready,
  input  logic [2*HALF_W-1:0]         a_data,
  input  logic                        b_valid,
  output logic                        b_ready,
  input  logic [2*HALF_W-1:0]         b_data,
  output logic                        o_valid,
  input  logic                        o_ready,
  output logic [NCHAN*2*HALF_W-1:0]   o_a_frame,
  output logic [NCHAN*2*HALF_W-1:0]   o_b_frame,
  output logic                        o_err
);
  localparam int BEAT_W = 2 * HALF_W;

  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic full_a, full_b, take_a, take_b;

  sca_deframer #(.NCHAN(NCHAN), .BEAT_W(BEAT_W)) u_dfa (
    .clk(clk), .rst_n(rst_int_n),
    .in_valid(a_valid), .in_ready(a_ready), .in_data(a_data),
    .take(take_a), .full(full_a), .frame(o_a_frame)
  );

  sca_deframer #(.NCHAN(NCHAN), .BEAT_W(BEAT_W)) u_dfb (
    .clk(clk), .rst_n(rst_int_n),
    .in_valid(b_valid), .in_ready(b_ready), .in_data(b_data),
    .take(take_b), .full(full_b), .frame(o_b_frame)
  );

  sca_align_ctrl #(.CNT_W(BEAT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_int_n),
    .full_a(full_a), .full_b(full_b),
    .cnt_a(o_a_frame[BEAT_W-1:0]), .cnt_b(o_b_frame[BEAT_W-1:0]),
    .out_ready(o_ready), .out_valid(o_valid),
    .take_a(take_a), .take_b(take_b), .err(o_err)
  );
endmodule

// File: rtl/sca_stream_aligner_chk.sv
module sca_stream_aligner_chk #(
  parameter int NCHAN  = 4,
  parameter int HALF_W = 16
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      a_ready,
  input logic                      b_ready,
  input logic                      o_valid,
  input logic                      o_ready,
  input logic [NCHAN*2*HALF_W-1:0] o_a_frame,
  input logic [NCHAN*2*HALF_W-1:0] o_b_frame,
  input logic                      o_err
);
  localparam int BW = 2 * HALF_W;

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (o_valid && !o_ready) |=> (o_valid && $stable(o_a_frame) && $stable(o_b_frame)));

  assert_stall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (o_valid && !o_ready) |-> (!a_ready && !b_ready));

  assert_match_R5: assert property (@(posedge clk) disable iff (!rst_n)
    o_valid |-> (o_a_frame[BW-1:0] == o_b_frame[BW-1:0]));

  assert_err_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    o_err |=> !o_err);

  assert_err_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    o_err |-> !o_valid);
endmodule

bind sca_stream_aligner sca_stream_aligner_chk #(.NCHAN(NCHAN), .HALF_W(HALF_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .a_ready(a_ready), .b_ready(b_ready),
  .o_valid(o_valid), .o_ready(o_ready), .o_a_frame(o_a_frame),
  .o_b_frame(o_b_frame), .o_err(o_err)
);

// File: tb/sim_sca_stream_aligner.sv
`timescale 1ns/1ps
module sim_sca_stream_aligner;
  localparam int NCHAN = 4;
  localparam int FW    = NCHAN * 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic a_valid = 1'b0, b_valid = 1'b0, o_ready = 1'b0;
  logic [31:0] a_data = '0, b_data = '0;
  logic a_ready, b_ready, o_valid, o_err;
  logic [FW-1:0] o_a_frame, o_b_frame;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  logic [31:0] qa[$];
  logic [31:0] qb[$];
  logic [31:0] qe[$];

  always #4 clk = ~clk;

  sca_stream_aligner #(.NCHAN(NCHAN), .HALF_W(16)) u0 (
    .clk(clk), .rst_n(rst_n),
    .a_valid(a_valid), .a_ready(a_ready), .a_data(a_data),
    .b_valid(b_valid), .b_ready(b_ready), .b_data(b_data),
    .o_valid(o_valid), .o_ready(o_ready),
    .o_a_frame(o_a_frame), .o_b_frame(o_b_frame), .o_err(o_err)
  );

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual cycle %0d expected < 150000", cyc);
      summary();
    end
  end

  task automatic chk(input string req, input logic [FW-1:0] act, input logic [FW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Slot 0 = sample number; slot k>0 = payload derived from the number.
  function automatic logic [FW-1:0] mk_frame(input int s, input logic [31:0] c);
    logic [FW-1:0] f;
    f = '0;
    f[31:0] = c;
    for (int k = 1; k < NCHAN; k++)
      f[k*32 +: 32] = {c[15:0] + 16'(k*257) + 16'(s*4099), c[31:16] ^ 16'(k)};
    return f;
  endfunction

  task automatic send_a(input int gap);
    for (int i = 0; i < qa.size(); i++) begin
      logic [FW-1:0] f;
      f = mk_frame(0, qa[i]);
      for (int k = 0; k < NCHAN; k++) begin
        int guard;
        @(negedge clk);
        if (gap != 0 && ((i + k) % gap) == 0) begin
          a_valid = 1'b0;
          @(negedge clk);
        end
        a_valid = 1'b1;
        a_data  = f[k*32 +: 32];
        #1;
        guard = 0;
        while (!a_ready && guard < 3000) begin
          @(negedge clk); #1; guard++;
        end
      end
    end
    @(negedge clk);
    a_valid = 1'b0;
  endtask

  task automatic send_b(input int gap);
    for (int i = 0; i < qb.size(); i++) begin
      logic [FW-1:0] f;
      f = mk_frame(1, qb[i]);
      for (int k = 0; k < NCHAN; k++) begin
        int guard;
        @(negedge clk);
        if (gap != 0 && ((i + k) % gap) == 1) begin
          b_valid = 1'b0;
          @(negedge clk);
        end
        b_valid = 1'b1;
        b_data  = f[k*32 +: 32];
        #1;
        guard = 0;
        while (!b_ready && guard < 3000) begin
          @(negedge clk); #1; guard++;
        end
      end
    end
    @(negedge clk);
    b_valid = 1'b0;
  endtask

  task automatic collect(input string tag, input int exp_err, input int mode);
    int got, errs, idle, extra;
    logic held;
    logic [FW-1:0] ha, hb;
    got = 0; errs = 0; idle = 0; extra = 0; held = 1'b0;
    while (got < qe.size() && idle < 3000) begin
      @(negedge clk);
      if (held) begin
        chk({tag, " R6 hold valid"}, FW'(o_valid), FW'(1));
        chk({tag, " R6 hold A"}, o_a_frame, ha);
        chk({tag, " R6 hold B"}, o_b_frame, hb);
      end
      o_ready = (mode == 0) ? 1'b1 : ((cyc % 3) != 0);
      #1;
      if (o_err) errs++;
      if (o_valid) begin
        if (o_ready) begin
          chk({tag, " R2 R5 frame A"}, o_a_frame, mk_frame(0, qe[got]));
          chk({tag, " R2 R5 frame B"}, o_b_frame, mk_frame(1, qe[got]));
          got++; held = 1'b0; idle = 0;
        end else begin
          held = 1'b1; ha = o_a_frame; hb = o_b_frame;
          chk({tag, " R6 inputs stalled"}, FW'({a_ready, b_ready}), FW'(0));
        end
      end else begin
        held = 1'b0; idle++;
      end
    end
    for (int t = 0; t < 20; t++) begin
      @(negedge clk);
      o_ready = 1'b1;
      #1;
      if (o_err) errs++;
      if (o_valid) extra++;
    end
    chk({tag, " R4 output count"}, FW'(got), FW'(qe.size()));
    chk({tag, " R4 no extra output"}, FW'(extra), FW'(0));
    chk({tag, " R7 err pulses"}, FW'(errs), FW'(exp_err));
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    a_valid = 1'b0; b_valid = 1'b0; o_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic run(input string tag, input int exp_err, input int mode, input int gap);
    fork
      send_a(gap);
      send_b(gap + 1);
      collect(tag, exp_err, mode);
    join
  endtask

  task automatic fill(input logic [31:0] a0, input int na, input logic [31:0] b0,
                      input int nb, input logic [31:0] e0, input int ne);
    qa.delete(); qb.delete(); qe.delete();
    for (int i = 0; i < na; i++) qa.push_back(a0 + 32'(i));
    for (int i = 0; i < nb; i++) qb.push_back(b0 + 32'(i));
    for (int i = 0; i < ne; i++) qe.push_back(e0 + 32'(i));
  endtask

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    #1;
    chk("R1 valid in reset", FW'(o_valid), FW'(0));
    chk("R1 err in reset", FW'(o_err), FW'(0));
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    chk("R1 ready after reset", FW'({a_ready, b_ready}), FW'(2'b11));
    chk("R1 valid after reset", FW'(o_valid), FW'(0));

    // R3: one side holds a full frame, other side idle
    qa.delete(); qa.push_back(32'd7);
    send_a(0);
    repeat (3) @(negedge clk);
    #1;
    chk("R3 a_ready held low", FW'(a_ready), FW'(0));
    chk("R3 b_ready stays high", FW'(b_ready), FW'(1));
    chk("R3 no output alone", FW'(o_valid), FW'(0));
    qb.delete(); qb.push_back(32'd7);
    qe.delete(); qe.push_back(32'd7);
    fork
      send_b(0);
      collect("R3 pair", 0, 0);
    join

    // R5: equal start, with backpressure
    do_reset(); fill(32'd5, 8, 32'd5, 8, 32'd5, 8); run("R5 equal", 0, 1, 0);
    // R4: A behind, B behind
    do_reset(); fill(32'd0, 10, 32'd4, 6, 32'd4, 6); run("R4 A late", 0, 1, 3);
    do_reset(); fill(32'd100, 6, 32'd90, 16, 32'd100, 6); run("R4 B late", 0, 0, 0);

    // R4 sweep of offsets
    for (int d = -3; d <= 3; d++) begin
      logic [31:0] sb, st;
      sb = 32'(1000 + d);
      st = (d > 0) ? sb : 32'd1000;
      do_reset();
      fill(32'd1000, 11, sb, 11 - d, st, 1011 - int'(st));
      run("R4 sweep", 0, d & 1, (d + 4) % 3);
    end

    // R8: wrap-around and half-range tie
    do_reset(); fill(32'hFFFF_FFFE, 5, 32'd1, 2, 32'd1, 2); run("R8 wrap", 0, 0, 0);
    do_reset();
    qa.delete(); qb.delete(); qe.delete();
    qa.push_back(32'h0); qa.push_back(32'h8000_0000);
    qb.push_back(32'h8000_0000); qe.push_back(32'h8000_0000);
    run("R8 tie", 0, 0, 0);

    // R7: slip while locked
    do_reset();
    qa.delete(); qb.delete(); qe.delete();
    for (int i = 10; i <= 12; i++) qa.push_back(32'(i));
    qa.push_back(32'd20); qa.push_back(32'd21);
    for (int i = 10; i <= 21; i++) qb.push_back(32'(i));
    for (int i = 10; i <= 12; i++) qe.push_back(32'(i));
    qe.push_back(32'd20); qe.push_back(32'd21);
    run("R7 slip", 1, 0, 0);

    summary();
  end
endmodule